// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Control

This block holds the pending interrupt state for up to four processors. Each processor has two pending bits: one for interprocessor interrupts (IPIs) and one for interval-timer interrupts. Each bit drives its own level output, so the two interrupt classes reach each processor on separate lines. Software changes the state through a single 16-bit control write. Within that word, one nibble posts IPIs, a second nibble retires IPIs, and a third nibble retires timer interrupts. Each nibble has one bit per processor.

A periodic tick from an external timer raises the timer interrupt on every present processor. A present-processor count decides which processors take part. Mask bits for processors beyond that count have no effect.

Two cases are software mistakes: posting an IPI that is already pending, and retiring an IPI that was never posted. Neither changes the state, but each raises a one-cycle warning pulse. A read returns both sets of pending bits and the number of the processor that is reading.

Top module: `ipi_timer_ctrl`

## Requirements
- R1: When `wr_en` is high, bit 12+i of `wr_data` sets the IPI pending bit of processor i. The bit is visible on `ipi_irq[i]` from the cycle after the write.
- R2: When `wr_en` is high, bit 8+i of `wr_data` clears the IPI pending bit of processor i from the cycle after the write.
- R3: When `wr_en` is high, bit 4+i of `wr_data` clears the timer pending bit of processor i from the cycle after the write.
- R4: A request for a processor whose IPI is already pending, with no clear for that processor in the same write, leaves the state unchanged. It drives `dup_warn` high for exactly the cycle after the write.
- R5: A clear for a processor with no IPI pending drives `clr_warn` high for exactly the cycle after the write.
- R6: A cycle with `tick` high sets the timer pending bit of every present processor from the next cycle.
- R7: When a tick and a timer clear for the same processor fall in the same cycle, the timer bit is pending afterwards.
- R8: When a request and a clear for the same processor arrive in one write, the clear is applied first. The IPI is pending afterwards and `dup_warn` is not raised for that processor.
- R9: Processor i is present when i < `cpu_cnt`; counts above 4 act as 4. Mask bits and ticks for absent processors change no state and raise no warning.
- R10: When `rd_en` is high, `rd_data` in the next cycle holds the IPI pending bits in 11:8, the timer pending bits in 7:4 and `rd_cpu` in 1:0. All other bits are zero, and the state shown is the state before any write in the same cycle. When `rd_en` is low, `rd_data` is zero in the next cycle.
- R11: A high `rst` at a clock edge clears all pending bits, both warnings and `rd_data`.
- R12: In a cycle with neither `wr_en` nor `tick`, the pending bits keep their values and both warnings are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cnt | input | 3 | Number of present processors |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 16 | Control write word: request 15:12, IPI clear 11:8, timer clear 7:4 |
| tick | input | 1 | Interval timer tick |
| rd_en | input | 1 | Read strobe |
| rd_cpu | input | 2 | Number of the reading processor |
| rd_data | output | 16 | Registered read word |
| ipi_irq | output | 4 | IPI level per processor |
| tmr_irq | output | 4 | Timer interrupt level per processor |
| dup_warn | output | 1 | Pulse: IPI requested while already pending |
| clr_warn | output | 1 | Pulse: IPI cleared while none pending |

## Verification
Two pairs of events can land in the same cycle. A tick can arrive together with a timer clear for the same processor, and one write can carry both an IPI request and an IPI clear for that processor. The bench sweeps every request nibble against every clear nibble, for each present-count from 0 to 4, under a tick at both levels and four timer-clear patterns. The pending state carries from one write to the next, so each collision is met with the bits both set and unset. After every cycle the bench compares both interrupt vectors, both warnings and the read word with a model built from the ordering rules: clear before request, tick over timer clear.

// File: rtl/ipi_timer_pkg.sv
package ipi_timer_pkg;
  localparam int MAX_CPU  = 4;
  localparam int CTRL_W   = 16;
  localparam int ID_W     = 2;
  localparam int REQ_LSB  = 12;
  localparam int ICLR_LSB = 8;
  localparam int TCLR_LSB = 4;
  localparam int RD_IPI_LSB = 8;
  localparam int RD_TMR_LSB = 4;
  localparam int RD_ID_LSB  = 0;

  typedef struct packed {
    logic [MAX_CPU-1:0] req;
    logic [MAX_CPU-1:0] iclr;
    logic [MAX_CPU-1:0] tclr;
  } ctrl_masks_t;

  function automatic ctrl_masks_t split_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_masks_t m;
    m.req  = w[REQ_LSB  +: MAX_CPU];
    m.iclr = w[ICLR_LSB +: MAX_CPU];
    m.tclr = w[TCLR_LSB +: MAX_CPU];
    return m;
  endfunction
endpackage

// File: rtl/ipi_present_decode.sv
module ipi_present_decode #(
  parameter int NUM_CPU = 4,
  parameter int CNT_W   = 3
) (
  input  logic [CNT_W-1:0]   cpu_cnt,
  output logic [NUM_CPU-1:0] present
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_CPU; gi++) begin : g_pres
      assign present[gi] = ({1'b0, cpu_cnt} > (CNT_W+1)'(gi));
    end
  endgenerate
endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic iclr,
  input  logic tclr,
  input  logic tick_en,
  output logic ipi_q,
  output logic tmr_q,
  output logic dup_hit,
  output logic none_hit
);
  // clear first, then request; a request surviving its own clear is no duplicate
  assign dup_hit  = req & ipi_q & ~iclr;
  assign none_hit = iclr & ~ipi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ipi_q <= 1'b0;
      tmr_q <= 1'b0;
    end else begin
      ipi_q <= (ipi_q & ~iclr) | req;
      // tick has priority over a coincident timer clear
      tmr_q <= (tmr_q & ~tclr) | tick_en;
    end
  end
endmodule

// File: rtl/ipi_read_fmt.sv
module ipi_read_fmt
  import ipi_timer_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ID_W-1:0]    rd_cpu,
  input  logic [NUM_CPU-1:0] ipi_q,
  input  logic [NUM_CPU-1:0] tmr_q,
  output logic [CTRL_W-1:0]  rd_data
);
  logic [CTRL_W-1:0] word;

  always_comb begin
    word = '0;
    word[RD_IPI_LSB +: NUM_CPU] = ipi_q;
    word[RD_TMR_LSB +: NUM_CPU] = tmr_q;
    word[RD_ID_LSB  +: ID_W]    = rd_cpu;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= word;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/ipi_timer_ctrl.sv
module ipi_timer_ctrl
  import ipi_timer_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CNT_W  = $clog2(MAX_CPU + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cpu_cnt,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic               tick,
  input  logic               rd_en,
  input  logic [ID_W-1:0]    rd_cpu,
  output logic [CTRL_W-1:0]  rd_data,
  output logic [NUM_CPU-1:0] ipi_irq,
  output logic [NUM_CPU-1:0] tmr_irq,
  output logic               dup_warn,
  output logic               clr_warn
);
  logic [NUM_CPU-1:0] present;
  logic [NUM_CPU-1:0] req_m, iclr_m, tclr_m, tick_m;
  logic [NUM_CPU-1:0] dup_v, none_v;
  ctrl_masks_t        masks;

  ipi_present_decode #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) u_pres (
    .cpu_cnt (cpu_cnt),
    .present (present)
  );

  assign masks  = split_ctrl(wr_data);
  assign req_m  = masks.req[NUM_CPU-1:0]  & present & {NUM_CPU{wr_en}};
  assign iclr_m = masks.iclr[NUM_CPU-1:0] & present & {NUM_CPU{wr_en}};
  assign tclr_m = masks.tclr[NUM_CPU-1:0] & present & {NUM_CPU{wr_en}};
  assign tick_m = present & {NUM_CPU{tick}};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CPU; gi++) begin : g_cpu
      ipi_cpu_slice u_slice (
        .clk      (clk),
        .rst      (rst),
        .req      (req_m[gi]),
        .iclr     (iclr_m[gi]),
        .tclr     (tclr_m[gi]),
        .tick_en  (tick_m[gi]),
        .ipi_q    (ipi_irq[gi]),
        .tmr_q    (tmr_irq[gi]),
        .dup_hit  (dup_v[gi]),
        .none_hit (none_v[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dup_warn <= 1'b0;
      clr_warn <= 1'b0;
    end else begin
      dup_warn <= |dup_v;
      clr_warn <= |none_v;
    end
  end

  ipi_read_fmt #(.NUM_CPU(NUM_CPU)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_cpu  (rd_cpu),
    .ipi_q   (ipi_irq),
    .tmr_q   (tmr_irq),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/ipi_timer_chk.sv
module ipi_timer_chk
  import ipi_timer_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [CNT_W-1:0]   cpu_cnt,
  input logic               wr_en,
  input logic [CTRL_W-1:0]  wr_data,
  input logic               tick,
  input logic               rd_en,
  input logic [ID_W-1:0]    rd_cpu,
  input logic [CTRL_W-1:0]  rd_data,
  input logic [NUM_CPU-1:0] ipi_irq,
  input logic [NUM_CPU-1:0] tmr_irq,
  input logic               dup_warn,
  input logic               clr_warn
);
  logic [NUM_CPU-1:0] pres, rq, ic, tc;
  logic [CTRL_W-1:0]  exp_rd;

  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) pres[i] = (int'(cpu_cnt) > i);
    rq = wr_data[REQ_LSB  +: NUM_CPU] & pres;
    ic = wr_data[ICLR_LSB +: NUM_CPU] & pres;
    tc = wr_data[TCLR_LSB +: NUM_CPU] & pres;
    exp_rd = '0;
    exp_rd[RD_IPI_LSB +: NUM_CPU] = ipi_irq;
    exp_rd[RD_TMR_LSB +: NUM_CPU] = tmr_irq;
    exp_rd[RD_ID_LSB  +: ID_W]    = rd_cpu;
  end

  AST_IPI_SET: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((ipi_irq & $past(rq)) == $past(rq))); // R1
  AST_IPI_CLR: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((ipi_irq & $past(ic & ~rq)) == '0)); // R2
  AST_TMR_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !tick) |=> ((tmr_irq & $past(tc)) == '0)); // R3
  AST_DUP_WARN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((rq & ipi_irq & ~ic) != '0)) |=> dup_warn); // R4
  AST_NONE_WARN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((ic & ~ipi_irq) != '0)) |=> clr_warn); // R5
  AST_TICK_SET: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((tmr_irq & $past(pres)) == $past(pres))); // R6
  AST_ABSENT_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((ipi_irq ^ $past(ipi_irq)) & ~$past(pres)) == '0)); // R9
  AST_READ_WORD: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data == $past(exp_rd))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !tick) |=> ($stable(ipi_irq) && $stable(tmr_irq) && !dup_warn && !clr_warn)); // R12
endmodule

bind ipi_timer_ctrl ipi_timer_chk #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_cnt(cpu_cnt), .wr_en(wr_en), .wr_data(wr_data),
  .tick(tick), .rd_en(rd_en), .rd_cpu(rd_cpu), .rd_data(rd_data),
  .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .dup_warn(dup_warn), .clr_warn(clr_warn)
);

// File: tb/tb_ipi_timer_ctrl.sv
module tb_ipi_timer_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cpu_cnt = 3'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_cpu = '0;
  logic [15:0] rd_data;
  logic [3:0]  ipi_irq, tmr_irq;
  logic        dup_warn, clr_warn;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [3:0] m_ipi = '0, m_tmr = '0;

  always #5 clk = ~clk;

  ipi_timer_ctrl dut (
    .clk(clk), .rst(rst), .cpu_cnt(cpu_cnt), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .rd_en(rd_en), .rd_cpu(rd_cpu), .rd_data(rd_data),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .dup_warn(dup_warn), .clr_warn(clr_warn)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, check at the next falling edge
  task automatic op(input int cnt, input logic [3:0] rq, input logic [3:0] ic,
                    input logic [3:0] tc, input bit tk, input bit rd, input logic [1:0] id);
    logic [3:0] p, erq, eic, etc, etk, n_ipi, n_tmr;
    logic [15:0] e_rd;
    bit we, e_dup, e_clr;
    p   = (cnt >= 4) ? 4'hF : 4'((5'd1 << cnt) - 5'd1);
    we  = (rq != 0) || (ic != 0) || (tc != 0);
    erq = we ? (rq & p) : 4'h0;
    eic = we ? (ic & p) : 4'h0;
    etc = we ? (tc & p) : 4'h0;
    etk = tk ? p : 4'h0;
    e_dup = |(erq & m_ipi & ~eic);
    e_clr = |(eic & ~m_ipi);
    e_rd  = rd ? {4'h0, m_ipi, m_tmr, 2'b00, id} : 16'h0;
    n_ipi = (m_ipi & ~eic) | erq;
    n_tmr = (m_tmr & ~etc) | etk;
    cpu_cnt = 3'(cnt);
    wr_en   = we;
    wr_data = {rq, ic, tc, 4'h0};
    tick    = tk;
    rd_en   = rd;
    rd_cpu  = id;
    @(posedge clk);
    @(negedge clk);
    chk(ipi_irq == n_ipi, "R1 R2 R8 R9 ipi_irq", 16'(ipi_irq), 16'(n_ipi));
    chk(tmr_irq == n_tmr, "R3 R6 R7 R9 tmr_irq", 16'(tmr_irq), 16'(n_tmr));
    chk(dup_warn == e_dup, "R4 R8 R9 dup_warn", 16'(dup_warn), 16'(e_dup));
    chk(clr_warn == e_clr, "R5 R9 clr_warn", 16'(clr_warn), 16'(e_clr));
    chk(rd_data == e_rd, "R10 rd_data", rd_data, e_rd);
    if (!we && !tk)
      chk(ipi_irq == m_ipi && tmr_irq == m_tmr && !dup_warn && !clr_warn,
          "R12 idle hold", {8'h0, ipi_irq, tmr_irq}, {8'h0, m_ipi, m_tmr});
    m_ipi = n_ipi;
    m_tmr = n_tmr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(ipi_irq == 0 && tmr_irq == 0 && !dup_warn && !clr_warn && rd_data == 0,
        "R11 reset state", {8'h0, ipi_irq, tmr_irq}, 16'h0);
    for (int cnt = 0; cnt <= 4; cnt++)
      for (int rq = 0; rq < 16; rq++)
        for (int ic = 0; ic < 16; ic++)
          for (int tc = 0; tc < 16; tc += 5)
            for (int tk = 0; tk < 2; tk++)
              op(cnt, 4'(rq), 4'(ic), 4'(tc), tk[0], rq[0] ^ ic[1], 2'(rq + tc));
    // saturation of the present count (values above 4)
    op(7, 4'hF, 4'h0, 4'h0, 1'b1, 1'b1, 2'd3);
    op(6, 4'h0, 4'hF, 4'hF, 1'b0, 1'b1, 2'd1);
    // mid-run reset with a write pending
    op(4, 4'hF, 4'h0, 4'h0, 1'b1, 1'b0, 2'd0);
    rst = 1'b1;
    wr_en = 1'b1;
    wr_data = 16'hF000;
    tick = 1'b1;
    rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(ipi_irq == 0 && tmr_irq == 0 && !dup_warn && !clr_warn && rd_data == 0,
        "R11 reset clears", {8'h0, ipi_irq, tmr_irq}, 16'h0);
    rst = 1'b0;
    m_ipi = '0;
    m_tmr = '0;
    op(4, 4'h5, 4'hA, 4'h0, 1'b0, 1'b1, 2'd2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule